// File: doc/BRIEF.md
# SIMD Increment and Absolute-Value Unit

This unit applies one of six single-operand integer operations to every lane of a packed word. The lane width is chosen per operation. It ranges from the minimum lane (8 bits by default) up to the full data width. The operations are increment, decrement, two's-complement negation, absolute value, index of the lowest clear bit, and index of the lowest set bit.

No adder is used. Each lane is first optionally inverted. A segmented prefix-AND tree then finds the run of ones that starts at the lane's bit 0. The arithmetic results come from XOR-toggling the bits up to and including the first zero. The index results count that run. An output register captures the result, so a result appears one clock after its inputs are presented.

Top module: `simd_incabs`

## Requirements
- R1: A synchronous active-high `rst` clears `result` to zero at the next rising clock edge.
- R2: `result` is registered. It shows the operation on `operand`, `opcode` and `size_sel` as sampled at the previous rising edge, and it does not change between edges.
- R3: Size code k selects lanes of MIN_LANE·2^k bits. Codes beyond the largest valid size select the full data width. No carry, borrow or index crosses a lane boundary.
- R4: Opcode encoding: 0 increment, 1 decrement, 2 negate, 3 absolute value, 4 lowest-zero index, 5 lowest-one index. Codes 6 and 7 return `operand` unchanged.
- R5: Increment adds one to each lane modulo 2^lane width, so an all-ones lane becomes zero.
- R6: Decrement subtracts one from each lane modulo 2^lane width, so a zero lane becomes all ones.
- R7: Negate gives the two's complement of each lane modulo 2^lane width. Zero stays zero and the most negative value stays unchanged.
- R8: Absolute value negates lanes whose top bit is set and leaves the others alone. The most negative value is returned unchanged.
- R9: Lowest-zero index returns, zero-extended in each lane, the bit position of the lane's lowest clear bit. A lane with no clear bit returns all ones.
- R10: Lowest-one index returns, zero-extended in each lane, the bit position of the lane's lowest set bit. A lane with no set bit returns all ones.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| operand | input | DATA_W | Packed lane data |
| opcode | input | 3 | Operation select |
| size_sel | input | 3 | Lane size code |
| result | output | DATA_W | Registered per-lane result |

## Verification
Byte lanes are loaded with the wrap-edge values 00, 01, 7F, 80, FE and FF side by side. This shows whether a carry or borrow escapes into the neighbouring lane, and whether the two ends of the signed range are handled. The same operations at 16-, 32- and 64-bit lanes, including a clamped size code, show whether the scan restarts at the right boundaries. Index tests mix lanes with the matching bit at position 0, in the middle, at the top, or missing altogether, which separates the counting path from the all-ones substitution. Opcodes 6 and 7, and a reset applied while inputs are active, confirm that nothing but the pass-through and the cleared state reach the output.

// File: rtl/simd_incabs_pkg.sv
package simd_incabs_pkg;
  localparam int OPC_W = 3;
  localparam int SZC_W = 3;

  localparam logic [OPC_W-1:0] OP_INC  = 3'd0;
  localparam logic [OPC_W-1:0] OP_DEC  = 3'd1;
  localparam logic [OPC_W-1:0] OP_NEG  = 3'd2;
  localparam logic [OPC_W-1:0] OP_ABS  = 3'd3;
  localparam logic [OPC_W-1:0] OP_LSB0 = 3'd4;
  localparam logic [OPC_W-1:0] OP_LSB1 = 3'd5;
endpackage

// File: rtl/simd_seg_scan.sv
// Segmented prefix AND: run_ones[i] is set when every bit from the start
// of i's lane up to and including i is one. Log-depth tree.
module simd_seg_scan #(
  parameter int W = 64
) (
  input  logic [W-1:0] bits_in,
  input  logic [W-1:0] seg_start,
  output logic [W-1:0] run_ones
);
  localparam int LV = $clog2(W);

  for (genvar l = 0; l < LV; l++) begin : g_lvl
    logic [W-1:0] v_in, f_in, v_out, f_out;
    if (l == 0) begin : g_src
      assign v_in = bits_in;
      assign f_in = seg_start;
    end else begin : g_src
      assign v_in = g_lvl[l-1].v_out;
      assign f_in = g_lvl[l-1].f_out;
    end
    always_comb begin
      for (int i = 0; i < W; i++) begin
        if (i < (1 << l)) begin
          v_out[i] = v_in[i];
          f_out[i] = f_in[i];
        end else begin
          v_out[i] = f_in[i] ? v_in[i] : (v_in[i] & v_in[i - (1 << l)]);
          f_out[i] = f_in[i] | f_in[i - (1 << l)];
        end
      end
    end
  end

  assign run_ones = g_lvl[LV-1].v_out;
endmodule

// File: rtl/simd_lane_index.sv
// Converts the trailing-ones mask of each lane into a zero-extended bit
// index, or all ones when the whole lane is ones.
module simd_lane_index #(
  parameter int W        = 64,
  parameter int MIN_LANE = 8,
  parameter int SH_W     = $clog2($clog2(W) + 1)
) (
  input  logic [W-1:0]    run_ones,
  input  logic [SH_W-1:0] lane_sh,
  output logic [W-1:0]    idx_word
);
  localparam int NL  = W / MIN_LANE;
  localparam int NLW = (NL > 1) ? $clog2(NL) : 1;
  localparam int CW  = $clog2(W) + 1;
  localparam int CIW = $clog2(CW);
  localparam int IW  = $clog2(W);

  logic [CW-1:0] cnt [NL];

  always_comb begin : p_idx
    int lw, ln, base, off;
    lw = 1 << lane_sh;
    for (int j = 0; j < NL; j++) cnt[j] = '0;
    for (int i = 0; i < W; i++) begin
      ln = i >> lane_sh;
      cnt[NLW'(ln)] = cnt[NLW'(ln)] + CW'(run_ones[i]);
    end
    for (int i = 0; i < W; i++) begin
      ln   = i >> lane_sh;
      base = ln << lane_sh;
      off  = i - base;
      if (run_ones[IW'(base + lw - 1)])
        idx_word[i] = 1'b1;
      else if (off < CW)
        idx_word[i] = cnt[NLW'(ln)][CIW'(off)];
      else
        idx_word[i] = 1'b0;
    end
  end
endmodule

// File: rtl/simd_incabs.sv
module simd_incabs
  import simd_incabs_pkg::*;
#(
  parameter int DATA_W   = 64,
  parameter int MIN_LANE = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [DATA_W-1:0] operand,
  input  logic [OPC_W-1:0]  opcode,
  input  logic [SZC_W-1:0]  size_sel,
  output logic [DATA_W-1:0] result
);
  localparam int LOG_MIN = $clog2(MIN_LANE);
  localparam int LOG_W   = $clog2(DATA_W);
  localparam int NSZ     = LOG_W - LOG_MIN + 1;
  localparam int SH_W    = $clog2(LOG_W + 1);
  localparam int IW      = $clog2(DATA_W);

  logic [SH_W-1:0]   lane_sh;
  logic [DATA_W-1:0] seg_start, flip, xsel, run_ones, tog, idx_word, nxt;

  // Stage 1: lane geometry and per-bit inversion select
  always_comb begin : p_lane
    int eff, lw, base;
    logic sgn;
    eff     = (int'(size_sel) > NSZ - 1) ? NSZ - 1 : int'(size_sel);
    lane_sh = SH_W'(LOG_MIN + eff);
    lw      = 1 << (LOG_MIN + eff);
    for (int i = 0; i < DATA_W; i++) begin
      base         = i & ~(lw - 1);
      seg_start[i] = (i == base);
      sgn          = operand[IW'(base + lw - 1)];
      case (opcode)
        OP_DEC, OP_NEG, OP_LSB1: flip[i] = 1'b1;
        OP_ABS:                  flip[i] = sgn;
        default:                 flip[i] = 1'b0;
      endcase
    end
  end

  assign xsel = operand ^ flip;

  // Stage 2: find the run of ones ending at each lane's first zero
  simd_seg_scan #(.W(DATA_W)) u_scan (
    .bits_in  (xsel),
    .seg_start(seg_start),
    .run_ones (run_ones)
  );

  // Toggle mask: bit 0 of each lane up to and including its first zero
  always_comb begin
    tog[0] = 1'b1;
    for (int i = 1; i < DATA_W; i++) tog[i] = seg_start[i] | run_ones[i-1];
  end

  simd_lane_index #(.W(DATA_W), .MIN_LANE(MIN_LANE), .SH_W(SH_W)) u_idx (
    .run_ones(run_ones),
    .lane_sh (lane_sh),
    .idx_word(idx_word)
  );

  // Stages 3-4: XOR and output select
  always_comb begin
    case (opcode)
      OP_INC, OP_DEC:   nxt = operand ^ tog;
      OP_NEG:           nxt = xsel ^ tog;
      OP_ABS:           nxt = xsel ^ (tog & flip);
      OP_LSB0, OP_LSB1: nxt = idx_word;
      default:          nxt = operand;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) result <= '0;
    else     result <= nxt;
  end
endmodule

// File: rtl/simd_incabs_chk.sv
module simd_incabs_chk
  import simd_incabs_pkg::*;
#(
  parameter int DATA_W   = 64,
  parameter int MIN_LANE = 8
) (
  input logic              clk,
  input logic              rst,
  input logic [DATA_W-1:0] operand,
  input logic [OPC_W-1:0]  opcode,
  input logic [SZC_W-1:0]  size_sel,
  input logic [DATA_W-1:0] result
);
  localparam int NSZ = $clog2(DATA_W) - $clog2(MIN_LANE) + 1;

  logic full_w;
  assign full_w = int'(size_sel) >= NSZ - 1;

  AST_RESET_ZERO: assert property (@(posedge clk) rst |=> result == '0); // R1
  AST_INC_WRAP: assert property (@(posedge clk) disable iff (rst)
    (full_w && opcode == OP_INC) |=> result == $past(operand) + DATA_W'(1)); // R5
  AST_DEC_WRAP: assert property (@(posedge clk) disable iff (rst)
    (full_w && opcode == OP_DEC) |=> result == $past(operand) - DATA_W'(1)); // R6
  AST_NEG_WRAP: assert property (@(posedge clk) disable iff (rst)
    (full_w && opcode == OP_NEG) |=> result == DATA_W'(0) - $past(operand)); // R7
  AST_ABS_FULL: assert property (@(posedge clk) disable iff (rst)
    (full_w && opcode == OP_ABS) |=> result ==
      ($past(operand[DATA_W-1]) ? DATA_W'(0) - $past(operand) : $past(operand))); // R8
  AST_PASS_UNUSED: assert property (@(posedge clk) disable iff (rst)
    (opcode > OP_LSB1) |=> result == $past(operand)); // R4
  AST_LSB0_NONE: assert property (@(posedge clk) disable iff (rst)
    (opcode == OP_LSB0 && (&operand)) |=> (&result)); // R9
  AST_LSB1_NONE: assert property (@(posedge clk) disable iff (rst)
    (opcode == OP_LSB1 && operand == '0) |=> (&result)); // R10
endmodule

bind simd_incabs simd_incabs_chk #(.DATA_W(DATA_W), .MIN_LANE(MIN_LANE)) u_chk (
  .clk(clk), .rst(rst), .operand(operand), .opcode(opcode),
  .size_sel(size_sel), .result(result)
);

// File: tb/sim_simd_incabs.sv
`timescale 1ns/1ps
module sim_simd_incabs;
  import simd_incabs_pkg::*;

  localparam int DW = 64;
  localparam int NV = 15;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [DW-1:0] operand = 64'hDEAD_BEEF_0BAD_F00D;
  logic [2:0]    opcode = OP_INC;
  logic [2:0]    size_sel = 3'd0;
  logic [DW-1:0] result;

  int n_cmp = 0;
  int n_bad = 0;

  always #2 clk = ~clk;

  simd_incabs #(.DATA_W(DW), .MIN_LANE(8)) u0 (
    .clk(clk), .rst(rst), .operand(operand), .opcode(opcode),
    .size_sel(size_sel), .result(result)
  );

  // {opcode, size code, operand, expected}
  localparam logic [133:0] VEC [NV] = '{
    {3'd0, 3'd0, 64'h00FF_7F80_0102_FE01, 64'h0100_8081_0203_FF02},
    {3'd1, 3'd0, 64'h00FF_7F80_0102_FE01, 64'hFFFE_7E7F_0001_FD00},
    {3'd2, 3'd0, 64'h0001_7F80_FF02_0A00, 64'h00FF_8180_01FE_F600},
    {3'd3, 3'd0, 64'h80FF_7F81_0005_F6C0, 64'h8001_7F7F_0005_0A40},
    {3'd3, 3'd1, 64'h8000_FFFF_00FF_FF01, 64'h8000_0001_00FF_00FF},
    {3'd0, 3'd2, 64'hFFFF_FFFF_0000_FFFF, 64'h0000_0000_0001_0000},
    {3'd1, 3'd3, 64'h0000_0000_0000_0000, 64'hFFFF_FFFF_FFFF_FFFF},
    {3'd4, 3'd0, 64'hFF00_0103_077F_FE17, 64'hFF00_0102_0307_0003},
    {3'd5, 3'd0, 64'h0001_0280_FF10_4000, 64'hFF00_0107_0004_06FF},
    {3'd4, 3'd3, 64'h0000_0000_FFFF_FFFF, 64'h0000_0000_0000_0020},
    {3'd5, 3'd1, 64'h8000_0000_0010_0001, 64'h000F_FFFF_0004_0000},
    {3'd2, 3'd3, 64'h0000_0000_0000_0001, 64'hFFFF_FFFF_FFFF_FFFF},
    {3'd0, 3'd7, 64'h0000_0000_FFFF_FFFF, 64'h0000_0001_0000_0000},
    {3'd6, 3'd0, 64'h1234_5678_9ABC_DEF0, 64'h1234_5678_9ABC_DEF0},
    {3'd3, 3'd2, 64'h8000_0000_FFFF_FFFE, 64'h8000_0000_0000_0002}
  };

  string tags [NV] = '{"R5 R3", "R6 R3", "R7", "R8", "R8 R3", "R5 R3", "R6",
                       "R9", "R10", "R9 R3", "R10 R3", "R7", "R3", "R4", "R8"};

  task automatic check(input string tag, input logic [DW-1:0] exp);
    n_cmp++;
    if (result !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, result, exp);
    end
  endtask

  task automatic apply(input logic [2:0] op, input logic [2:0] sz, input logic [DW-1:0] val);
    @(negedge clk);
    opcode   = op;
    size_sel = sz;
    operand  = val;
    @(posedge clk);
    #1;
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 check("R1 reset state", '0);
    @(negedge clk) rst = 1'b0;

    for (int k = 0; k < NV; k++) begin
      apply(VEC[k][133:131], VEC[k][130:128], VEC[k][127:64]);
      check(tags[k], VEC[k][63:0]);
    end

    // R2: output holds until the edge, then updates
    @(negedge clk);
    opcode = OP_INC; size_sel = 3'd3; operand = 64'd5;
    #1 check("R2 hold before edge", 64'h8000_0000_0000_0002);
    @(posedge clk);
    #1 check("R2 update after edge", 64'd6);

    // R4: opcode 7 passes the operand through
    apply(3'd7, 3'd2, 64'hA5A5_0000_FFFF_0001);
    check("R4 opcode 7", 64'hA5A5_0000_FFFF_0001);

    // R1: reset while inputs are active
    @(negedge clk);
    rst = 1'b1; opcode = OP_DEC; operand = 64'h1111_2222_3333_4444;
    @(posedge clk);
    #1 check("R1 reset mid-run", '0);
    @(negedge clk) rst = 1'b0;

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    #80000;
    n_cmp++;
    n_bad++;
    $display("FAIL R2 watchdog: actual hung expected finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule